// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block serves one transmit channel. It walks a table of transmit buffer descriptors in memory and passes each ready buffer to a downstream send engine. Each descriptor is one 64-bit word. Bit 63 is the ready flag and bit 62 is the wrap flag. Bits 47:32 hold the buffer length in bytes and bits 31:0 hold the buffer pointer. Bits 61:48 are carried through unchanged. The address of a descriptor is the programmed table base plus eight times the current offset, where the offset counts descriptors.

Software fills the table and then pulses a start command. The sequencer reads the descriptor at the current offset over a valid/ready read/write request port. Read data comes back as a single-beat response. If the descriptor is ready, the sequencer starts the send engine with the pointer and length, and waits for the engine's done signal. It then writes the descriptor back with the ready bit cleared, which returns ownership to software. After the write it steps the offset, and returns the offset to zero after a descriptor that has its wrap flag set.

When a fetched descriptor is not ready, there are two behaviours:
- With auto-deactivate off, the sequencer fetches that descriptor again on every channel-rate tick.
- With auto-deactivate on, the sequencer drops its active flag and waits for a new start command. That command resumes at the same offset.

Top module: `txbd_ring_seq`

## Requirements
- R1: During and after reset `active` is 0, `cur_offset` is 0, and neither `mem_req_valid` nor `snd_start` is asserted.
- R2: A `cmd_start` pulse while inactive makes `active` 1 and raises a read request (`mem_req_we`=0) in the next cycle.
- R3: Every memory request carries address `cfg_tbl_base + 8*cur_offset`.
- R4: For a fetched descriptor with bit 63 set, `snd_start` rises in the cycle right after the read response. It carries `snd_ptr` = bits 31:0 and `snd_len` = bits 47:32, and successive buffers are sent in table order.
- R5: After `snd_done`, the block issues a write request to the same descriptor address. The written data equals the descriptor with bit 63 cleared and every other bit unchanged.
- R6: Once that write is accepted, `cur_offset` increases by one, or becomes 0 if the descriptor has bit 62 set.
- R7: When a descriptor is not ready and `cfg_auto_off`=0, `active` stays 1 and no request is issued until `rate_tick` is pulsed. A read request appears in the cycle after the tick.
- R8: When a descriptor is not ready and `cfg_auto_off`=1, `active` falls to 0 and the offset is kept. No request is issued, even on ticks, until `cmd_start`, which then reads at the kept offset.
- R9: `cmd_start` while `active` is 1 has no effect on the offset or on the request stream.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address stay unchanged.
- R11: `snd_start` is a single-cycle pulse for each buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tbl_base | input | 32 | Byte address of descriptor 0 |
| cfg_auto_off | input | 1 | 1: deactivate on a not-ready descriptor |
| cmd_start | input | 1 | Start command pulse |
| rate_tick | input | 1 | Channel-rate tick used for re-polling |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write-back, 0 = descriptor read |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_req_wdata | output | 64 | Write-back data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Read response descriptor |
| snd_start | output | 1 | Start pulse to the send engine |
| snd_ptr | output | 32 | Buffer pointer |
| snd_len | output | 16 | Buffer length in bytes |
| snd_done | input | 1 | Send engine finished the buffer |
| active | output | 1 | Channel in service |
| cur_offset | output | 8 | Current descriptor offset |

## Verification
A wrong offset shows up at once: the next memory request goes to the wrong address, and the model memory then returns a descriptor whose pointer and length do not match the scoreboard queue at the following `snd_start`. A missed write-back shows up later. It leaves a ready bit set in the model memory, so the ring keeps resending instead of settling into polling, and the queue underflows on the next wrap. A wrong polling or deactivation state shows up within one tick as a request that should not exist, or as a missing one, and the `active` flag exposes it directly.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WAIT, S_ISSUE, S_SEND, S_WBACK, S_POLL
  } seq_state_t;

  typedef struct packed {
    logic        rdy;
    logic        wrap;
    logic [13:0] spare;
    logic [15:0] len;
    logic [31:0] ptr;
  } txbd_t;

  localparam int unsigned DESC_BYTES = 8;
endpackage

// File: rtl/txbd_offset.sv
module txbd_offset #(
  parameter int unsigned OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             wrap_i,
  output logic [OFF_W-1:0] offset_o
);
  logic [OFF_W-1:0] off_q, off_d;

  always_comb begin
    off_d = off_q;
    if (step_i) off_d = wrap_i ? '0 : off_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (step_i) off_q <= off_d;
  end

  assign offset_o = off_q;

  p_offset_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(off_q) |-> (off_q == '0) || (off_q == $past(off_q) + 1'b1));
endmodule

// File: rtl/txbd_addr.sv
module txbd_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned SH = $clog2(txbd_pkg::DESC_BYTES);

  assign addr_o = base_i + (ADDR_W'(offset_i) << SH);
endmodule

// File: rtl/txbd_ctrl.sv
module txbd_ctrl
  import txbd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cmd_start,
  input  logic  auto_off,
  input  logic  rate_tick,
  input  logic  req_ready,
  input  logic  rsp_valid,
  input  txbd_t rsp_desc,
  input  logic  snd_done,
  output logic  req_valid,
  output logic  req_we,
  output txbd_t wb_desc,
  output logic  snd_start,
  output txbd_t cur_desc,
  output logic  step,
  output logic  wrap,
  output logic  active
);
  seq_state_t state_q, state_d;
  txbd_t      desc_q;
  logic       ld_desc;

  always_comb begin
    state_d   = state_q;
    req_valid = 1'b0;
    req_we    = 1'b0;
    snd_start = 1'b0;
    step      = 1'b0;
    ld_desc   = 1'b0;
    unique case (state_q)
      S_IDLE:  if (cmd_start) state_d = S_FETCH;
      S_FETCH: begin
        req_valid = 1'b1;
        if (req_ready) state_d = S_WAIT;
      end
      S_WAIT: if (rsp_valid) begin
        if (rsp_desc.rdy) begin
          ld_desc = 1'b1;
          state_d = S_ISSUE;
        end else if (auto_off) begin
          state_d = S_IDLE;
        end else begin
          state_d = S_POLL;
        end
      end
      S_ISSUE: begin
        snd_start = 1'b1;
        state_d   = S_SEND;
      end
      S_SEND:  if (snd_done) state_d = S_WBACK;
      S_WBACK: begin
        req_valid = 1'b1;
        req_we    = 1'b1;
        if (req_ready) begin
          step    = 1'b1;
          state_d = S_FETCH;
        end
      end
      S_POLL:  if (rate_tick) state_d = S_FETCH;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       desc_q <= '0;
    else if (ld_desc) desc_q <= rsp_desc;
  end

  always_comb begin
    wb_desc     = desc_q;
    wb_desc.rdy = 1'b0;
  end

  assign cur_desc = desc_q;
  assign wrap     = desc_q.wrap;
  assign active   = (state_q != S_IDLE);

  p_snd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    snd_start |=> !snd_start);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_we));
  p_wb_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && !$past(req_valid && req_we)) |-> $past(snd_done));
  p_tick_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_POLL) && rate_tick |=> req_valid && !req_we);
  p_deact_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(rsp_valid) && $past(auto_off));
endmodule

// File: rtl/txbd_ring_seq.sv
module txbd_ring_seq
  import txbd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_tbl_base,
  input  logic              cfg_auto_off,
  input  logic              cmd_start,
  input  logic              rate_tick,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [63:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              snd_start,
  output logic [31:0]       snd_ptr,
  output logic [15:0]       snd_len,
  input  logic              snd_done,
  output logic              active,
  output logic [OFF_W-1:0]  cur_offset
);
  txbd_t rsp_desc, wb_desc, cur_desc;
  logic  step, wrap;

  assign rsp_desc = txbd_t'(mem_rsp_data);

  txbd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .auto_off  (cfg_auto_off),
    .rate_tick (rate_tick),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .rsp_desc  (rsp_desc),
    .snd_done  (snd_done),
    .req_valid (mem_req_valid),
    .req_we    (mem_req_we),
    .wb_desc   (wb_desc),
    .snd_start (snd_start),
    .cur_desc  (cur_desc),
    .step      (step),
    .wrap      (wrap),
    .active    (active)
  );

  txbd_offset #(.OFF_W(OFF_W)) u_off (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (step),
    .wrap_i   (wrap),
    .offset_o (cur_offset)
  );

  txbd_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .base_i   (cfg_tbl_base),
    .offset_i (cur_offset),
    .addr_o   (mem_req_addr)
  );

  assign mem_req_wdata = wb_desc;
  assign snd_ptr       = cur_desc.ptr;
  assign snd_len       = cur_desc.len;

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr));
  p_wb_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> !mem_req_wdata[63]);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !$past(active) |-> !snd_start);
endmodule

// File: tb/sim_txbd_ring_seq.sv
module sim_txbd_ring_seq;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cfg_auto_off, cmd_start, rate_tick;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        snd_start, snd_done, active;
  logic [31:0] snd_ptr;
  logic [15:0] snd_len;
  logic [7:0]  cur_offset;

  logic [63:0] mem [0:15];
  logic [47:0] exp_q [$];
  int total = 0, bad = 0, cyc = 0, busy = 0, last_rsp = -10, req_cnt = 0;
  logic stall_en = 1'b0, rdy_tog = 1'b0, prev_stall = 1'b0, prev_snd = 1'b0;
  logic [31:0] prev_addr = '0;

  txbd_ring_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_tbl_base(BASE), .cfg_auto_off(cfg_auto_off),
    .cmd_start(cmd_start), .rate_tick(rate_tick),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .snd_start(snd_start), .snd_ptr(snd_ptr), .snd_len(snd_len), .snd_done(snd_done),
    .active(active), .cur_offset(cur_offset)
  );

  function automatic logic [63:0] mk(input logic r, input logic w,
                                     input logic [15:0] len, input logic [31:0] p);
    return {r, w, 14'h1a5, len, p};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  assign mem_req_ready = !stall_en || rdy_tog;
  assign snd_done      = (busy == 1);

  always @(posedge clk) begin
    logic [31:0] d;
    cyc     <= cyc + 1;
    rdy_tog <= ~rdy_tog;
    mem_rsp_valid <= 1'b0;
    d = (mem_req_addr - BASE) >> 3;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[d[3:0]] <= mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[d[3:0]];
      end
    end
    if (!rst_n)         busy <= 0;
    else if (snd_start) busy <= 3;
    else if (busy > 0)  busy <= busy - 1;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (mem_rsp_valid) last_rsp = cyc;
    if (mem_req_valid && mem_req_ready) req_cnt++;
    if (mem_req_valid)
      chk(mem_req_addr == BASE + 32'(cur_offset) * 8, "R3 request address",
          64'(mem_req_addr), 64'(BASE + 32'(cur_offset) * 8));
    if (prev_stall)
      chk(mem_req_valid && mem_req_addr == prev_addr, "R10 stalled request held",
          64'(mem_req_addr), 64'(prev_addr));
    if (snd_start) begin
      chk(!prev_snd, "R11 single-cycle start", 64'(prev_snd), 64'd0);
      chk(cyc == last_rsp + 1, "R4 start right after response", 64'(cyc), 64'(last_rsp + 1));
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected buffer", {snd_len, snd_ptr}, 64'd0);
      else begin
        logic [47:0] e;
        e = exp_q.pop_front();
        chk({snd_len, snd_ptr} == e, "R4 pointer/length", {snd_len, snd_ptr}, 64'(e));
      end
    end
    prev_snd   = snd_start;
    prev_stall = mem_req_valid && !mem_req_ready;
    prev_addr  = mem_req_addr;
  end

  task automatic pulse_start();
    @(negedge clk) cmd_start = 1'b1;
    @(negedge clk) cmd_start = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk) rate_tick = 1'b1;
    @(negedge clk) rate_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'(cyc), 64'd0);
    finish_run();
  end

  initial begin
    int c;
    rst_n = 1'b0; cfg_auto_off = 1'b0; cmd_start = 1'b0; rate_tick = 1'b0;
    for (int i = 0; i < 16; i++) mem[i] <= '0;
    repeat (3) @(negedge clk);
    chk(!active && !mem_req_valid && !snd_start, "R1 in reset", {active, mem_req_valid, snd_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cur_offset == 0 && !active, "R1 after reset", {cur_offset, active}, 0);

    // pass 1: four ready descriptors, wrap on the last, stalled request port
    for (int i = 0; i < 4; i++) begin
      mem[i] <= mk(1'b1, i == 3, 16'(64 + 8 * i), 32'h8000_0000 + 32'(i * 256));
      exp_q.push_back({16'(64 + 8 * i), 32'h8000_0000 + 32'(i * 256)});
    end
    stall_en = 1'b1;
    pulse_start();
    chk(active && mem_req_valid && !mem_req_we && mem_req_addr == BASE, "R2 start launches read",
        {active, mem_req_valid, mem_req_we, mem_req_addr}, {3'b110, BASE});
    repeat (150) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all buffers sent", 64'(exp_q.size()), 0);
    chk(cur_offset == 0, "R6 wrap to zero", 64'(cur_offset), 0);
    for (int i = 0; i < 4; i++)
      chk(mem[i] == mk(1'b0, i == 3, 16'(64 + 8 * i), 32'h8000_0000 + 32'(i * 256)),
          "R5 write-back clears ready only", mem[i],
          mk(1'b0, i == 3, 16'(64 + 8 * i), 32'h8000_0000 + 32'(i * 256)));
    chk(active, "R7 polling keeps active", 64'(active), 1);
    c = req_cnt;
    repeat (20) @(negedge clk);
    chk(req_cnt == c, "R7 no request without tick", 64'(req_cnt), 64'(c));

    // start while active is ignored
    pulse_start();
    repeat (5) @(negedge clk);
    chk(req_cnt == c && cur_offset == 0 && active, "R9 start while active ignored",
        {req_cnt[15:0], cur_offset, 7'd0, active}, {c[15:0], 16'd1});

    // re-arm descriptor 0 and tick
    stall_en = 1'b0;
    mem[0] <= mk(1'b1, 1'b0, 16'd300, 32'hA000_0040);
    exp_q.push_back({16'd300, 32'hA000_0040});
    pulse_tick();
    chk(mem_req_valid && !mem_req_we, "R7 fetch right after tick", {mem_req_valid, mem_req_we}, 2'b10);
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0 && cur_offset == 1, "R6 step after send",
        {exp_q.size(), cur_offset}, {32'd0, 8'd1});

    // auto-deactivate
    cfg_auto_off = 1'b1;
    pulse_tick();
    repeat (10) @(negedge clk);
    chk(!active && cur_offset == 1, "R8 deactivated, offset kept", {active, cur_offset}, {1'b0, 8'd1});
    c = req_cnt;
    repeat (10) @(negedge clk);
    pulse_tick();
    repeat (10) @(negedge clk);
    chk(req_cnt == c && !active, "R8 idle ignores ticks", 64'(req_cnt), 64'(c));

    mem[1] <= mk(1'b1, 1'b0, 16'd12, 32'hB000_0000);
    exp_q.push_back({16'd12, 32'hB000_0000});
    pulse_start();
    chk(mem_req_valid && mem_req_addr == BASE + 8, "R8 restart at kept offset",
        64'(mem_req_addr), 64'(BASE + 8));
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0 && !active && cur_offset == 2, "R8 deactivates on next not-ready",
        {exp_q.size(), active, cur_offset}, {32'd0, 1'b0, 8'd2});
    finish_run();
  end
endmodule